// File: doc/BRIEF.md
# Hashed Inverted Page Table Walker

This block translates a virtual page number and process identifier into a real address using an inverted page table kept in a local register array. The table has one entry for each physical frame, so its size depends only on the frame count, not on how many processes or virtual pages are in use. Each entry holds a page number, a process identifier, a valid flag, an end-of-chain flag and a link to the next entry.

A lookup folds the page number into a starting entry index. The walker then examines one entry per clock cycle and follows the link fields until an entry matches on both page number and process identifier, or until the chain ends. The position of the matching entry is the frame number. That frame number, followed by the page offset, forms the real address. Software fills the table through a single-entry write port. The walker takes a new request only after the previous one has been answered.

Top module: `ipt_walker`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `rsp_valid_o` is 0.
- R2: The first entry examined has index `(vpn[VPN_W-1:VPN_W/2] ^ vpn[VPN_W/2-1:0])`, truncated or zero-extended to FRAME_W bits.
- R3: An entry matches only when its valid flag is 1, its page number equals the requested page number and its process identifier equals the requested one. On a match, `rsp_hit_o` is 1 and `rsp_frame_o` is the index of the matching entry.
- R4: On a hit, `rsp_addr_o` equals `{rsp_frame_o, offset}`: the frame number in the upper FRAME_W bits and the request offset in the lower OFF_W bits.
- R5: When an examined entry is valid, does not match and does not have its end-of-chain flag set, the next entry examined is the one that its link field names.
- R6: The lookup ends with `rsp_hit_o` = 0 when the examined entry does not match and either has its end-of-chain flag set or is invalid.
- R7: A lookup that has examined 2^FRAME_W entries without a match or a chain end ends with `rsp_hit_o` = 0. This bounds looped chains.
- R8: A lookup that examines k entries raises `rsp_valid_o` for exactly one cycle, after the k-th rising edge following the edge that accepted it. `req_ready_o` stays 0 from acceptance until that response cycle ends, and requests presented in that time are ignored.
- R9: An entry written through the write port while the walker is idle is used by the next lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Walker idle; request taken on this edge |
| req_vpn_i | input | VPN_W | Virtual page number |
| req_pid_i | input | PID_W | Process identifier |
| req_off_i | input | OFF_W | Offset within page |
| rsp_valid_o | output | 1 | Response valid, one cycle |
| rsp_hit_o | output | 1 | 1 = translation found, 0 = fault |
| rsp_frame_o | output | FRAME_W | Frame number (index of matching entry) |
| rsp_addr_o | output | FRAME_W+OFF_W | Real address {frame, offset} |
| wr_en_i | input | 1 | Table write strobe |
| wr_idx_i | input | FRAME_W | Entry index to write |
| wr_vld_i | input | 1 | Entry valid flag |
| wr_last_i | input | 1 | Entry end-of-chain flag |
| wr_vpn_i | input | VPN_W | Entry page number |
| wr_pid_i | input | PID_W | Entry process identifier |
| wr_link_i | input | FRAME_W | Entry chain link |

## Verification
The first sweep loads a table of scattered page numbers, process identifiers, links, end-of-chain flags and one invalid entry. It then looks up every page number with every process identifier from 0 to 3, so that a fault caused by a wrong process is told apart from a fault caused by a wrong page. It also separates a hit at the head of a chain from a hit deeper in the chain, and an invalid-entry stop from an end-of-chain stop. For each lookup, the number of cycles until the response is compared with a walk computed in the bench, which exposes a wrong hash index or a wrong link taken. A second table links every entry into one closed ring. Lookups in it show the guard ending a walk after exactly the table size, and a request held during that walk shows that requests are not taken while the walker is busy.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_RESP} walk_st_e;
endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
  parameter int VPN_W = 8,
  parameter int IDX_W = 4
) (
  input  logic [VPN_W-1:0] vpn_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam int HALF = VPN_W / 2;

  logic [HALF-1:0] fold;
  assign fold = vpn_i[VPN_W-1 -: HALF] ^ vpn_i[HALF-1:0];

  generate
    if (HALF >= IDX_W) begin : g_trunc
      assign idx_o = fold[IDX_W-1:0];
    end else begin : g_ext
      assign idx_o = {{(IDX_W-HALF){1'b0}}, fold};
    end
  endgenerate
endmodule

// File: rtl/ipt_table.sv
module ipt_table #(
  parameter int VPN_W = 8,
  parameter int PID_W = 4,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_vld_i,
  input  logic             wr_last_i,
  input  logic [VPN_W-1:0] wr_vpn_i,
  input  logic [PID_W-1:0] wr_pid_i,
  input  logic [IDX_W-1:0] wr_link_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_vld_o,
  output logic             rd_last_o,
  output logic [VPN_W-1:0] rd_vpn_o,
  output logic [PID_W-1:0] rd_pid_o,
  output logic [IDX_W-1:0] rd_link_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]            vld_q;
  logic [DEPTH-1:0]            last_q;
  logic [DEPTH-1:0][VPN_W-1:0] vpn_q;
  logic [DEPTH-1:0][PID_W-1:0] pid_q;
  logic [DEPTH-1:0][IDX_W-1:0] link_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      last_q <= '0;
      vpn_q  <= '0;
      pid_q  <= '0;
      link_q <= '0;
    end else if (wr_en_i) begin
      vld_q[wr_idx_i]  <= wr_vld_i;
      last_q[wr_idx_i] <= wr_last_i;
      vpn_q[wr_idx_i]  <= wr_vpn_i;
      pid_q[wr_idx_i]  <= wr_pid_i;
      link_q[wr_idx_i] <= wr_link_i;
    end
  end

  assign rd_vld_o  = vld_q[rd_idx_i];
  assign rd_last_o = last_q[rd_idx_i];
  assign rd_vpn_o  = vpn_q[rd_idx_i];
  assign rd_pid_o  = pid_q[rd_idx_i];
  assign rd_link_o = link_q[rd_idx_i];

  // R9: a written entry holds the written fields on the next cycle
  p_write_lands_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (vpn_q[$past(wr_idx_i)] == $past(wr_vpn_i)) &&
                (pid_q[$past(wr_idx_i)] == $past(wr_pid_i)) &&
                (vld_q[$past(wr_idx_i)] == $past(wr_vld_i)));
endmodule

// File: rtl/ipt_walk.sv
module ipt_walk
  import ipt_pkg::*;
#(
  parameter int VPN_W = 8,
  parameter int PID_W = 4,
  parameter int IDX_W = 4,
  parameter int OFF_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VPN_W-1:0] req_vpn_i,
  input  logic [PID_W-1:0] req_pid_i,
  input  logic [OFF_W-1:0] req_off_i,
  input  logic [IDX_W-1:0] head_idx_i,
  output logic [IDX_W-1:0] rd_idx_o,
  input  logic             ent_vld_i,
  input  logic             ent_last_i,
  input  logic [VPN_W-1:0] ent_vpn_i,
  input  logic [PID_W-1:0] ent_pid_i,
  input  logic [IDX_W-1:0] ent_link_i,
  output logic             rsp_valid_o,
  output logic             rsp_hit_o,
  output logic [IDX_W-1:0] rsp_frame_o,
  output logic [OFF_W-1:0] rsp_off_o
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LAST_CNT = IDX_W'(DEPTH - 1);

  walk_st_e         st_q;
  logic [IDX_W-1:0] cur_q, cnt_q, frame_q;
  logic [VPN_W-1:0] vpn_q;
  logic [PID_W-1:0] pid_q;
  logic [OFF_W-1:0] off_q;
  logic             hit_q;
  logic             match, stop;

  assign match = ent_vld_i && (ent_vpn_i == vpn_q) && (ent_pid_i == pid_q);
  // invalid entry, chain end or guard limit terminates the walk
  assign stop  = !ent_vld_i || ent_last_i || (cnt_q == LAST_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cur_q   <= '0;
      cnt_q   <= '0;
      frame_q <= '0;
      vpn_q   <= '0;
      pid_q   <= '0;
      off_q   <= '0;
      hit_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          st_q  <= ST_WALK;
          cur_q <= head_idx_i;
          cnt_q <= '0;
          vpn_q <= req_vpn_i;
          pid_q <= req_pid_i;
          off_q <= req_off_i;
        end
        ST_WALK: begin
          if (match || stop) begin
            hit_q   <= match;
            frame_q <= cur_q;
            st_q    <= ST_RESP;
          end else begin
            cur_q <= ent_link_i;
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign rsp_valid_o = (st_q == ST_RESP);
  assign rsp_hit_o   = hit_q;
  assign rsp_frame_o = frame_q;
  assign rsp_off_o   = off_q;
  assign rd_idx_o    = cur_q;

  p_start_hash_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (rd_idx_o == $past(head_idx_i)));

  p_hit_frame_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WALK && match) |=> rsp_valid_o && rsp_hit_o && (rsp_frame_o == $past(cur_q)));

  p_follow_link_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WALK && !match && !stop) |=> !rsp_valid_o && (rd_idx_o == $past(ent_link_i)));

  p_last_miss_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WALK && ent_last_i && !match) |=> rsp_valid_o && !rsp_hit_o);

  p_guard_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WALK && cnt_q == LAST_CNT) |=> rsp_valid_o);

  p_accept_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  p_single_rsp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o);
endmodule

// File: rtl/ipt_walker.sv
module ipt_walker #(
  parameter int VPN_W   = 8,
  parameter int PID_W   = 4,
  parameter int FRAME_W = 4,
  parameter int OFF_W   = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic [VPN_W-1:0]         req_vpn_i,
  input  logic [PID_W-1:0]         req_pid_i,
  input  logic [OFF_W-1:0]         req_off_i,
  output logic                     rsp_valid_o,
  output logic                     rsp_hit_o,
  output logic [FRAME_W-1:0]       rsp_frame_o,
  output logic [FRAME_W+OFF_W-1:0] rsp_addr_o,
  input  logic                     wr_en_i,
  input  logic [FRAME_W-1:0]       wr_idx_i,
  input  logic                     wr_vld_i,
  input  logic                     wr_last_i,
  input  logic [VPN_W-1:0]         wr_vpn_i,
  input  logic [PID_W-1:0]         wr_pid_i,
  input  logic [FRAME_W-1:0]       wr_link_i
);
  logic [FRAME_W-1:0] head_idx, rd_idx, ent_link;
  logic               ent_vld, ent_last;
  logic [VPN_W-1:0]   ent_vpn;
  logic [PID_W-1:0]   ent_pid;
  logic [OFF_W-1:0]   rsp_off;

  ipt_hash #(.VPN_W(VPN_W), .IDX_W(FRAME_W)) u_hash (
    .vpn_i (req_vpn_i),
    .idx_o (head_idx)
  );

  ipt_table #(.VPN_W(VPN_W), .PID_W(PID_W), .IDX_W(FRAME_W)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_vld_i  (wr_vld_i),
    .wr_last_i (wr_last_i),
    .wr_vpn_i  (wr_vpn_i),
    .wr_pid_i  (wr_pid_i),
    .wr_link_i (wr_link_i),
    .rd_idx_i  (rd_idx),
    .rd_vld_o  (ent_vld),
    .rd_last_o (ent_last),
    .rd_vpn_o  (ent_vpn),
    .rd_pid_o  (ent_pid),
    .rd_link_o (ent_link)
  );

  ipt_walk #(.VPN_W(VPN_W), .PID_W(PID_W), .IDX_W(FRAME_W), .OFF_W(OFF_W)) u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_vpn_i   (req_vpn_i),
    .req_pid_i   (req_pid_i),
    .req_off_i   (req_off_i),
    .head_idx_i  (head_idx),
    .rd_idx_o    (rd_idx),
    .ent_vld_i   (ent_vld),
    .ent_last_i  (ent_last),
    .ent_vpn_i   (ent_vpn),
    .ent_pid_i   (ent_pid),
    .ent_link_i  (ent_link),
    .rsp_valid_o (rsp_valid_o),
    .rsp_hit_o   (rsp_hit_o),
    .rsp_frame_o (rsp_frame_o),
    .rsp_off_o   (rsp_off)
  );

  assign rsp_addr_o = {rsp_frame_o, rsp_off};

  p_addr_join_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> ##[0:0] (rsp_addr_o[OFF_W-1:0] == $past(req_off_i)));
endmodule

// File: tb/ipt_walker_test.sv
module ipt_walker_test;
  localparam int VPN_W = 8, PID_W = 4, FRAME_W = 4, OFF_W = 4;
  localparam int DEPTH = 1 << FRAME_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, wr_en = 1'b0, wr_vld = 1'b0, wr_last = 1'b0;
  logic [VPN_W-1:0] req_vpn = '0, wr_vpn = '0;
  logic [PID_W-1:0] req_pid = '0, wr_pid = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic [FRAME_W-1:0] wr_idx = '0, wr_link = '0;
  logic req_ready, rsp_valid, rsp_hit;
  logic [FRAME_W-1:0] rsp_frame;
  logic [FRAME_W+OFF_W-1:0] rsp_addr;

  int checks = 0, errors = 0;

  // bench copy of what was written
  logic [DEPTH-1:0] m_vld, m_last;
  logic [VPN_W-1:0] m_vpn [DEPTH];
  logic [PID_W-1:0] m_pid [DEPTH];
  logic [FRAME_W-1:0] m_link [DEPTH];

  always #4 clk = ~clk;

  ipt_walker #(.VPN_W(VPN_W), .PID_W(PID_W), .FRAME_W(FRAME_W), .OFF_W(OFF_W)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vpn_i(req_vpn), .req_pid_i(req_pid), .req_off_i(req_off),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_frame_o(rsp_frame), .rsp_addr_o(rsp_addr),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_vld_i(wr_vld), .wr_last_i(wr_last),
    .wr_vpn_i(wr_vpn), .wr_pid_i(wr_pid), .wr_link_i(wr_link)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input int idx, input bit v, input bit l, input int vpn, input int pid, input int link);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = FRAME_W'(idx); wr_vld = v; wr_last = l;
    wr_vpn = VPN_W'(vpn); wr_pid = PID_W'(pid); wr_link = FRAME_W'(link);
    m_vld[idx] = v; m_last[idx] = l; m_vpn[idx] = VPN_W'(vpn);
    m_pid[idx] = PID_W'(pid); m_link[idx] = FRAME_W'(link);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // reference walk: R2 fold, R3 match, R5 link, R6 stop, R7 guard
  task automatic ref_walk(input int vpn, input int pid, output bit hit, output int frame, output int steps);
    int idx;
    idx = ((vpn >> 4) ^ vpn) & (DEPTH - 1);
    hit = 1'b0; frame = 0; steps = 0;
    for (int s = 1; s <= DEPTH; s++) begin
      steps = s;
      if (m_vld[idx] && m_vpn[idx] == VPN_W'(vpn) && m_pid[idx] == PID_W'(pid)) begin
        hit = 1'b1; frame = idx; return;
      end
      if (!m_vld[idx] || m_last[idx]) return;
      idx = m_link[idx];
    end
  endtask

  task automatic lookup(input int vpn, input int pid, input int off, input bit hold_busy);
    bit e_hit; int e_frame, e_steps, n;
    ref_walk(vpn, pid, e_hit, e_frame, e_steps);
    @(negedge clk);
    req_valid = 1'b1; req_vpn = VPN_W'(vpn); req_pid = PID_W'(pid); req_off = OFF_W'(off);
    @(posedge clk);
    @(negedge clk);
    if (hold_busy) begin
      req_vpn = ~req_vpn; req_pid = ~req_pid;
    end else req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < DEPTH + 4) begin
      if (hold_busy) chk(!req_ready, "R8 ready low while busy", int'(req_ready), 0);
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    chk(n == e_steps, "R8/R2/R5 response latency", n, e_steps);
    chk(rsp_hit == e_hit, "R3/R6/R7 hit flag", int'(rsp_hit), int'(e_hit));
    if (e_hit) begin
      chk(int'(rsp_frame) == e_frame, "R3 frame", int'(rsp_frame), e_frame);
      chk(int'(rsp_addr) == (e_frame * (1 << OFF_W) + off), "R4 address", int'(rsp_addr),
          e_frame * (1 << OFF_W) + off);
    end
    @(negedge clk);
    chk(!rsp_valid && req_ready, "R8 single response cycle", int'(rsp_valid), 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_vld = '0; m_last = '0;
    for (int i = 0; i < DEPTH; i++) begin
      m_vpn[i] = '0; m_pid[i] = '0; m_link[i] = '0;
    end
    #3;
    chk(req_ready && !rsp_valid, "R1 reset state", int'(rsp_valid), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R1 after reset", int'(req_ready), 1);

    // empty table: head entry invalid, one step, miss (R6)
    lookup(8'h3c, 0, 5, 1'b0);

    // scattered table, one invalid entry (R9 fills it)
    for (int f = 0; f < DEPTH; f++)
      put(f, f != 7, (f % 3) == 0, (f * 37 + 5) & 255, f & 3, (f * 5 + 3) & (DEPTH - 1));
    for (int p = 0; p < 4; p++)
      for (int v = 0; v < 256; v++)
        lookup(v, p, v & 15, 1'b0);

    // ring: no chain ends, guard stops the walk after DEPTH entries (R7)
    for (int f = 0; f < DEPTH; f++)
      put(f, 1'b1, 1'b0, f + 100, 0, (f + 1) & (DEPTH - 1));
    lookup(8'hff, 1, 2, 1'b1);
    lookup(103, 0, 9, 1'b1);
    lookup(103, 1, 9, 1'b0);
    // R9: rewrite one ring entry, next lookup sees it
    put(5, 1'b1, 1'b1, 200, 2, 0);
    lookup(200, 2, 1, 1'b0);
    lookup(8'hff, 1, 2, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule